// File: doc/BRIEF.md
# AES Round-Key Expansion Unit

This unit turns an AES cipher key of 128, 192 or 256 bits into the complete set of 128-bit round keys. It sends them out as a stream, one key per beat, each tagged with its index. A start strobe captures the key, a key-size code and a direction bit. The unit then generates the schedule and reports the number of cipher rounds. A one-cycle done pulse closes each request.

In encryption direction, the keys stream out as they are generated. In decryption direction, the encryption keys are first collected in a local store and then sent out in reverse order. Every key except the two end keys passes through the inverse column-mixing transform. The result is the schedule used by the equivalent inverse cipher. The S-box is computed in logic from the field inverse and the affine map, so the unit needs no table.

Top module: `aes_key_sched`

## Requirements
- R1: The size code `klen_i` selects the key size: 0 for 128 bits, 1 for 192 bits, 2 for 256 bits. The round count on `rounds_o` is then 10, 12 or 14. It is valid from the cycle after start is accepted and holds until the next accepted start. It is 0 after reset.
- R2: Size code 3 is rejected. `rounds_o` becomes 0, no round key is emitted (`rk_valid_o` stays low), and `done_o` still pulses once.
- R3: For a valid size with N rounds, exactly N+1 keys are emitted, with `rk_idx_o` running 0, 1, …, N. In encryption direction, key 0 equals `key_i[127:0]`.
- R4: Key byte j sits on `key_i[8j+7:8j]`, and byte j of a round key sits on `rk_o[8j+7:8j]`. Words are four consecutive bytes, and the lowest-addressed byte is in the word's low bits. The encryption round keys follow the standard AES expansion. Round constants 01,02,04,08,10,20,40,80,1B,36 are applied in that order to the low byte of the rotated, substituted word.
- R5: For 256-bit keys, the word in the middle of each eight-word step is substituted byte-wise, with no rotation and no round constant.
- R6: For 192-bit keys, round keys are assembled across six-word generation steps, so keys 1, 4, 7 and 10 each mix words from two steps.
- R7: With `dec_i`=1, output key i is encryption key N−i. Keys 1..N−1 have the inverse column-mixing transform applied to each 32-bit column. Output 0 is encryption key N and output N is encryption key 0, both unchanged.
- R8: `done_o` is high for exactly one cycle, in the cycle right after the last round key. It is never high together with `rk_valid_o`.
- R9: A start strobe while a request is in progress is ignored. The running request's keys and round count are unaffected.
- R10: For 128-bit and 192-bit keys, the unused upper bits of `key_i` have no effect on any output.
- R11: The keys of one request come out on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| klen_i | input | 2 | Key-size code (0:128, 1:192, 2:256, 3:invalid) |
| dec_i | input | 1 | 1 selects the decryption schedule |
| key_i | input | 256 | Cipher key, byte j on bits 8j+7:8j |
| rk_valid_o | output | 1 | Round key beat valid |
| rk_idx_o | output | 4 | Index of the round key on `rk_o` |
| rk_o | output | 128 | Round key |
| rounds_o | output | 4 | Round count of the last accepted request (0 if rejected) |
| done_o | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench targets the last round key of each key size. A wrong round-constant order, or a missing constant, corrupts exactly those late keys while the early ones look right. The 192-bit case is exercised through the straddling keys 1, 4, 7 and 10. A design that aligns steps to round keys would emit shuffled halves there. The 256-bit middle transform is checked as well, since a rotation or constant there breaks every odd key from 3 onward. Decryption runs check that the end keys skip the column transform and that the order is reversed. A start pulse injected mid-run, random garbage in the unused key bits, and the rejected size code each catch a design that latches inputs at the wrong time or emits stray keys.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  localparam int WORD_W    = 32;
  localparam int RK_WORDS  = 4;
  localparam int RK_W      = WORD_W * RK_WORDS;
  localparam int KEY_WORDS = 8;
  localparam int KEY_W     = WORD_W * KEY_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_GEN, ST_REV, ST_FIN} ks_state_e;

  localparam logic [1:0] KSEL_128 = 2'd0;
  localparam logic [1:0] KSEL_192 = 2'd1;
  localparam logic [1:0] KSEL_256 = 2'd2;

  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = gf_x2(t);
    end
    return acc;
  endfunction

  // a^254 by a fixed square-and-multiply chain; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] a2, a3, a6, a7, a12, a15, a30, a60, a120, a127;
    a2   = gf_mul(a, a);
    a3   = gf_mul(a2, a);
    a6   = gf_mul(a3, a3);
    a7   = gf_mul(a6, a);
    a12  = gf_mul(a6, a6);
    a15  = gf_mul(a12, a3);
    a30  = gf_mul(a15, a15);
    a60  = gf_mul(a30, a30);
    a120 = gf_mul(a60, a60);
    a127 = gf_mul(a120, a7);
    return gf_mul(a127, a127);
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] i;
    i = gf_inv(a);
    return i ^ {i[6:0], i[7]} ^ {i[5:0], i[7:6]} ^ {i[4:0], i[7:5]}
             ^ {i[3:0], i[7:4]} ^ 8'h63;
  endfunction

  function automatic word_t sub_word(input word_t w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  // byte 1 moves to byte 0, byte 0 moves to byte 3
  function automatic word_t rot_word(input word_t w);
    return {w[7:0], w[31:8]};
  endfunction

  function automatic word_t inv_mix_word(input word_t w);
    logic [7:0] b0, b1, b2, b3;
    b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16]; b3 = w[31:24];
    return {gf_mul(b0, 8'h0b) ^ gf_mul(b1, 8'h0d) ^ gf_mul(b2, 8'h09) ^ gf_mul(b3, 8'h0e),
            gf_mul(b0, 8'h0d) ^ gf_mul(b1, 8'h09) ^ gf_mul(b2, 8'h0e) ^ gf_mul(b3, 8'h0b),
            gf_mul(b0, 8'h09) ^ gf_mul(b1, 8'h0e) ^ gf_mul(b2, 8'h0b) ^ gf_mul(b3, 8'h0d),
            gf_mul(b0, 8'h0e) ^ gf_mul(b1, 8'h0b) ^ gf_mul(b2, 8'h0d) ^ gf_mul(b3, 8'h09)};
  endfunction
endpackage

// File: rtl/aes_ks_wordgen.sv
// Produces four consecutive schedule words per cycle from the last eight.
module aes_ks_wordgen
  import aes_ks_pkg::*;
(
  input  word_t [KEY_WORDS-1:0] hist_i,
  input  word_t [KEY_WORDS-1:0] key_w_i,
  input  logic  [5:0]           wcnt_i,
  input  logic  [2:0]           phase_i,
  input  logic  [3:0]           nk_i,
  input  logic  [7:0]           rcon_i,
  output word_t [RK_WORDS-1:0]  new_w_o,
  output logic  [2:0]           phase_nx_o,
  output logic                  rcon_adv_o
);
  word_t      prev, back, xf, res;
  logic [5:0] idx;
  logic [3:0] ph_raw, ph, bsel, ph4;

  always_comb begin
    prev       = hist_i[KEY_WORDS-1];
    rcon_adv_o = 1'b0;
    idx = '0; ph_raw = '0; ph = '0; bsel = '0; back = '0; xf = '0; res = '0;
    for (int j = 0; j < RK_WORDS; j++) begin
      idx    = wcnt_i + 6'(j);
      ph_raw = {1'b0, phase_i} + 4'(j);
      ph     = (ph_raw >= nk_i) ? ph_raw - nk_i : ph_raw;
      bsel   = 4'(KEY_WORDS) - nk_i + 4'(j);
      back   = hist_i[bsel[2:0]];
      if (ph == 4'd0)
        xf = sub_word(rot_word(prev)) ^ {24'h0, rcon_i};
      else if (nk_i == 4'd8 && ph == 4'd4)
        xf = sub_word(prev);
      else
        xf = prev;
      if (idx < {2'b00, nk_i}) begin
        res = key_w_i[idx[2:0]];
      end else begin
        res = back ^ xf;
        if (ph == 4'd0) rcon_adv_o = 1'b1;
      end
      new_w_o[j] = res;
      prev       = res;
    end
    ph4        = {1'b0, phase_i} + 4'd4;
    phase_nx_o = (ph4 >= nk_i) ? 3'(ph4 - nk_i) : ph4[2:0];
  end
endmodule

// File: rtl/aes_ks_imc.sv
// Inverse column mixing on each of the four columns of a round key.
module aes_ks_imc
  import aes_ks_pkg::*;
(
  input  logic [RK_W-1:0] d_i,
  output logic [RK_W-1:0] q_o
);
  for (genvar c = 0; c < RK_WORDS; c++) begin : g_col
    assign q_o[c*WORD_W +: WORD_W] = inv_mix_word(d_i[c*WORD_W +: WORD_W]);
  end
endmodule

// File: rtl/aes_ks_rkbuf.sv
// Holds encryption round keys so they can be replayed in reverse.
module aes_ks_rkbuf #(
  parameter int DEPTH = 15,
  parameter int W     = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // R7: the reverse store is never written past its depth
  p_wr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (int'(waddr_i) < DEPTH));
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
  import aes_ks_pkg::*;
#(
  parameter int MAX_ROUNDS = 14,
  localparam int DEPTH = MAX_ROUNDS + 1,
  localparam int CNT_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       klen_i,
  input  logic             dec_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             rk_valid_o,
  output logic [CNT_W-1:0] rk_idx_o,
  output logic [RK_W-1:0]  rk_o,
  output logic [CNT_W-1:0] rounds_o,
  output logic             done_o
);
  ks_state_e             state_q, state_d;
  logic [KEY_W-1:0]      key_q, key_d;
  logic [3:0]            nk_q, nk_d;
  logic                  dec_q, dec_d;
  logic [CNT_W-1:0]      rounds_q, rounds_d, cnt_q, cnt_d;
  word_t [KEY_WORDS-1:0] hist_q, hist_d;
  logic [5:0]            wcnt_q, wcnt_d;
  logic [2:0]            phase_q, phase_d;
  logic [7:0]            rcon_q, rcon_d;
  logic                  vld_q, vld_d, done_q, done_d;
  logic [CNT_W-1:0]      idx_q, idx_d;
  logic [RK_W-1:0]       rk_q, rk_d;

  word_t [RK_WORDS-1:0]  gen_w;
  logic [2:0]            gen_phase;
  logic                  gen_radv;
  logic [RK_W-1:0]       gen_rk, rd_rk, rd_imc;
  logic                  buf_we;
  logic [CNT_W-1:0]      rd_addr;

  aes_ks_wordgen u_wordgen (
    .hist_i     (hist_q),
    .key_w_i    (key_q),
    .wcnt_i     (wcnt_q),
    .phase_i    (phase_q),
    .nk_i       (nk_q),
    .rcon_i     (rcon_q),
    .new_w_o    (gen_w),
    .phase_nx_o (gen_phase),
    .rcon_adv_o (gen_radv)
  );

  assign gen_rk  = gen_w;
  assign buf_we  = (state_q == ST_GEN) && dec_q;
  assign rd_addr = rounds_q - cnt_q;

  aes_ks_rkbuf #(.DEPTH(DEPTH), .W(RK_W)) u_rkbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (buf_we),
    .waddr_i (cnt_q),
    .wdata_i (gen_rk),
    .raddr_i (rd_addr),
    .rdata_o (rd_rk)
  );

  aes_ks_imc u_imc (.d_i(rd_rk), .q_o(rd_imc));

  // next-state logic
  always_comb begin
    state_d  = state_q;
    key_d    = key_q;
    nk_d     = nk_q;
    dec_d    = dec_q;
    rounds_d = rounds_q;
    cnt_d    = cnt_q;
    hist_d   = hist_q;
    wcnt_d   = wcnt_q;
    phase_d  = phase_q;
    rcon_d   = rcon_q;
    vld_d    = 1'b0;
    done_d   = 1'b0;
    idx_d    = idx_q;
    rk_d     = rk_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          key_d   = key_i;
          dec_d   = dec_i;
          cnt_d   = '0;
          hist_d  = '0;
          wcnt_d  = '0;
          phase_d = '0;
          rcon_d  = 8'h01;
          state_d = ST_GEN;
          unique case (klen_i)
            KSEL_128: begin nk_d = 4'd4; rounds_d = CNT_W'(10); end
            KSEL_192: begin nk_d = 4'd6; rounds_d = CNT_W'(12); end
            KSEL_256: begin nk_d = 4'd8; rounds_d = CNT_W'(14); end
            default:  begin nk_d = 4'd4; rounds_d = '0; state_d = ST_FIN; end
          endcase
        end
      end
      ST_GEN: begin
        hist_d[RK_WORDS-1:0]         = hist_q[KEY_WORDS-1:RK_WORDS];
        hist_d[KEY_WORDS-1:RK_WORDS] = gen_w;
        wcnt_d  = wcnt_q + 6'(RK_WORDS);
        phase_d = gen_phase;
        if (gen_radv) rcon_d = gf_x2(rcon_q);
        if (!dec_q) begin
          vld_d = 1'b1;
          idx_d = cnt_q;
          rk_d  = gen_rk;
        end
        if (cnt_q == rounds_q) begin
          cnt_d   = '0;
          state_d = dec_q ? ST_REV : ST_FIN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REV: begin
        vld_d = 1'b1;
        idx_d = cnt_q;
        rk_d  = (cnt_q == '0 || cnt_q == rounds_q) ? rd_rk : rd_imc;
        if (cnt_q == rounds_q) state_d = ST_FIN;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_FIN: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      key_q    <= '0;
      nk_q     <= 4'd4;
      dec_q    <= 1'b0;
      rounds_q <= '0;
      cnt_q    <= '0;
      hist_q   <= '0;
      wcnt_q   <= '0;
      phase_q  <= '0;
      rcon_q   <= 8'h01;
      vld_q    <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      rk_q     <= '0;
    end else begin
      state_q  <= state_d;
      key_q    <= key_d;
      nk_q     <= nk_d;
      dec_q    <= dec_d;
      rounds_q <= rounds_d;
      cnt_q    <= cnt_d;
      hist_q   <= hist_d;
      wcnt_q   <= wcnt_d;
      phase_q  <= phase_d;
      rcon_q   <= rcon_d;
      vld_q    <= vld_d;
      done_q   <= done_d;
      idx_q    <= idx_d;
      rk_q     <= rk_d;
    end
  end

  assign rk_valid_o = vld_q;
  assign rk_idx_o   = idx_q;
  assign rk_o       = rk_q;
  assign rounds_o   = rounds_q;
  assign done_o     = done_q;

  // R1: only the three legal round counts or the reject value appear
  p_rounds_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rounds_o inside {CNT_W'(0), CNT_W'(10), CNT_W'(12), CNT_W'(14)});
  // R2: a rejected request emits no keys
  p_reject_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rounds_o == '0) |-> !rk_valid_o);
  // R3: index never exceeds the round count
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid_o |-> (rk_idx_o <= rounds_o));
  // R3/R11: a non-zero index follows its predecessor in the previous cycle
  p_idx_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid_o && rk_idx_o != '0) |->
      ($past(rk_valid_o) && (CNT_W'($past(rk_idx_o) + 1'b1) == rk_idx_o)));
  // R8: done is a single-cycle pulse, never alongside a key beat
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_no_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rk_valid_o);
  // R9: the captured key does not change while a request runs
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(key_q));
endmodule

// File: tb/aes_key_sched_tb_top.sv
`timescale 1ns/1ps
module aes_key_sched_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   klen_i;
  logic         dec_i;
  logic [255:0] key_i;
  logic         rk_valid_o;
  logic [3:0]   rk_idx_o;
  logic [127:0] rk_o;
  logic [3:0]   rounds_o;
  logic         done_o;

  always #2.5 clk = ~clk;

  aes_key_sched dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .klen_i(klen_i), .dec_i(dec_i),
    .key_i(key_i), .rk_valid_o(rk_valid_o), .rk_idx_o(rk_idx_o), .rk_o(rk_o),
    .rounds_o(rounds_o), .done_o(done_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0]   sb [256];
  logic [127:0] exp_rk [15];
  logic [127:0] got [15];
  int got_cnt, first_cyc, last_cyc, done_cyc, done_cnt, idx_err;
  bit mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (rk_valid_o) begin
        if (got_cnt == 0) first_cyc = cyc;
        if (int'(rk_idx_o) != got_cnt) idx_err++;
        if (got_cnt < 15) got[got_cnt] = rk_o;
        got_cnt++;
        last_cyc = cyc;
      end
      if (done_o) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m2(input logic [7:0] a);
    return a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= t;
      t = m2(t);
    end
    return r;
  endfunction

  // S-box by exhaustive inverse search and the affine map
  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = 8'h63;
      for (int k = 0; k < 5; k++) s ^= 8'((inv << k) | (inv >> (8 - k)));
      sb[x] = s;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [7:0] rc(input int n);
    case (n)
      1: return 8'h01; 2: return 8'h02; 3: return 8'h04; 4: return 8'h08;
      5: return 8'h10; 6: return 8'h20; 7: return 8'h40; 8: return 8'h80;
      9: return 8'h1b; default: return 8'h36;
    endcase
  endfunction

  function automatic logic [31:0] imcw(input logic [31:0] w);
    logic [7:0] a0 = w[7:0], a1 = w[15:8], a2 = w[23:16], a3 = w[31:24];
    logic [7:0] o0, o1, o2, o3;
    o0 = gm(a0, 8'h0e) ^ gm(a1, 8'h0b) ^ gm(a2, 8'h0d) ^ gm(a3, 8'h09);
    o1 = gm(a0, 8'h09) ^ gm(a1, 8'h0e) ^ gm(a2, 8'h0b) ^ gm(a3, 8'h0d);
    o2 = gm(a0, 8'h0d) ^ gm(a1, 8'h09) ^ gm(a2, 8'h0e) ^ gm(a3, 8'h0b);
    o3 = gm(a0, 8'h0b) ^ gm(a1, 8'h0d) ^ gm(a2, 8'h09) ^ gm(a3, 8'h0e);
    return {o3, o2, o1, o0};
  endfunction

  function automatic logic [255:0] to_bus(input logic [255:0] lit, input int nb);
    logic [255:0] r = '0;
    for (int j = 0; j < nb; j++) r[8*j +: 8] = lit[8*(nb-1-j) +: 8];
    return r;
  endfunction

  function automatic int nr_of(input logic [1:0] kl);
    return (kl == 2'd0) ? 10 : (kl == 2'd1) ? 12 : (kl == 2'd2) ? 14 : 0;
  endfunction

  task automatic build_expected(input logic [255:0] key, input logic [1:0] kl, input bit dec);
    logic [31:0] w [60];
    logic [127:0] enc [15];
    int nr = nr_of(kl);
    int nk = nr - 6;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] t;
      if (i < nk) w[i] = key[32*i +: 32];
      else begin
        t = w[i-1];
        if (i % nk == 0) t = subw({t[7:0], t[31:8]}) ^ {24'h0, rc(i / nk)};
        else if (nk > 6 && i % nk == 4) t = subw(t);
        w[i] = w[i-nk] ^ t;
      end
    end
    for (int k = 0; k < 15; k++) enc[k] = {w[4*k+3], w[4*k+2], w[4*k+1], w[4*k]};
    for (int k = 0; k <= nr; k++) begin
      if (!dec || k == 0 || k == nr) exp_rk[k] = dec ? enc[nr-k] : enc[k];
      else exp_rk[k] = {imcw(enc[nr-k][127:96]), imcw(enc[nr-k][95:64]),
                        imcw(enc[nr-k][63:32]), imcw(enc[nr-k][31:0])};
    end
  endtask

  task automatic run(input logic [255:0] key, input logic [1:0] kl, input bit dec,
                     input bit intf, input string req);
    int nr = nr_of(kl);
    build_expected(key, kl, dec);
    @(negedge clk);
    got_cnt = 0; done_cnt = 0; idx_err = 0; first_cyc = 0; last_cyc = 0; done_cyc = 0;
    mon_on = 1'b1;
    key_i = key; klen_i = kl; dec_i = dec; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    key_i = ~key; klen_i = 2'd3; dec_i = ~dec;
    if (intf) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; klen_i = 2'd2;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int t = 0; t < 100 && done_cnt == 0; t++) @(posedge clk);
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    chk(int'(rounds_o) == nr, "R1", {req, " round count"}, 128'(rounds_o), 128'(nr));
    chk(got_cnt == (nr == 0 ? 0 : nr + 1), nr == 0 ? "R2" : "R3", {req, " key count"},
        128'(got_cnt), 128'(nr == 0 ? 0 : nr + 1));
    chk(idx_err == 0, "R3", {req, " index order"}, 128'(idx_err), 128'(0));
    chk(done_cnt == 1, "R8", {req, " done pulses"}, 128'(done_cnt), 128'(1));
    if (nr != 0) begin
      chk(done_cyc == last_cyc + 1, "R8", {req, " done after last key"},
          128'(done_cyc), 128'(last_cyc + 1));
      chk(last_cyc - first_cyc + 1 == got_cnt, "R11", {req, " gap-free stream"},
          128'(last_cyc - first_cyc + 1), 128'(got_cnt));
      for (int k = 0; k <= nr && k < got_cnt; k++)
        chk(got[k] == exp_rk[k], dec ? "R7" : "R4", $sformatf("%s key %0d", req, k),
            got[k], exp_rk[k]);
      if (!dec)
        chk(got[0] == key[127:0], "R3", {req, " key 0 is key prefix"}, got[0], key[127:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=<150000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] k128, k192, k256, rk;
    int unsigned seedv;
    seedv = $urandom(32'd7411);
    rst_n = 1'b0; start_i = 1'b0; klen_i = 2'd0; dec_i = 1'b0; key_i = '0;
    build_sbox();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rk_valid_o && !done_o, "R8", "reset outputs idle", {126'd0, rk_valid_o, done_o}, 128'd0);
    chk(rounds_o == 4'd0, "R1", "reset round count", 128'(rounds_o), 128'd0);

    k128 = to_bus(256'h2b7e151628aed2a6abf7158809cf4f3c, 16);
    k192 = to_bus(256'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 24);
    k256 = to_bus(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 32);

    run(k128, 2'd0, 1'b0, 1'b0, "R4 kat128");
    rk = to_bus(256'hd014f9a8c9ee2589e13f0cc8b6630ca6, 16);
    chk(got[10] == rk[127:0], "R4", "128-bit last key known answer", got[10], rk[127:0]);
    run(k192, 2'd1, 1'b0, 1'b0, "R6 kat192");
    rk = to_bus(256'he98ba06f448c773c8ecc720401002202, 16);
    chk(got[12] == rk[127:0], "R6", "192-bit last key known answer", got[12], rk[127:0]);
    run(k256, 2'd2, 1'b0, 1'b0, "R5 kat256");
    rk = to_bus(256'hfe4890d1e6188d0b046df344706c631e, 16);
    chk(got[14] == rk[127:0], "R5", "256-bit last key known answer", got[14], rk[127:0]);

    run(k128, 2'd0, 1'b1, 1'b0, "R7 dec128");
    rk = to_bus(256'hd014f9a8c9ee2589e13f0cc8b6630ca6, 16);
    chk(got[0] == rk[127:0], "R7", "decrypt key 0 is last encrypt key", got[0], rk[127:0]);
    run(k192, 2'd1, 1'b1, 1'b0, "R7 dec192");
    run(k256, 2'd2, 1'b1, 1'b0, "R7 dec256");
    chk(got[14] == k256[127:0], "R7", "decrypt last key is key prefix", got[14], k256[127:0]);

    run(k256, 2'd3, 1'b0, 1'b0, "R2 reject");
    run(k128, 2'd0, 1'b0, 1'b1, "R9 busy start enc");
    run(k192, 2'd1, 1'b1, 1'b1, "R9 busy start dec");

    for (int it = 0; it < 12; it++) begin
      logic [255:0] rk_key;
      logic [1:0] kl;
      for (int q = 0; q < 8; q++) rk_key[32*q +: 32] = $urandom;
      kl = 2'($urandom % 3);
      run(rk_key, kl, 1'($urandom), 1'b0, $sformatf("R10 random %0d", it));
    end
    run({128'h0, k128[127:0]} | {~128'h0, 128'h0}, 2'd0, 1'b0, 1'b0, "R10 high bits set");
    rk = to_bus(256'hd014f9a8c9ee2589e13f0cc8b6630ca6, 16);
    chk(got[10] == rk[127:0], "R10", "upper key bits ignored", got[10], rk[127:0]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule